// File: doc/BRIEF.md
# Two-Lane Interleaved Sample Serializer

This block is the transmit end of a two-lane serial link for converter samples. Once per sample period it takes a 12-bit sample and an overrange flag. It holds each sample in a six-deep latency pipeline. It then sends the sample out as bit pairs, one pair per fast-clock cycle. The first lane carries the odd-numbered data bits and the second lane carries the even-numbered data bits, with the most significant bits first.

Both lanes end each sample with a filler slot that repeats the overrange flag. One of two frame formats adds a second, constant-zero slot after it, so a sample takes either eight or seven fast-clock cycles. A frame output marks the sample boundaries for the receiver.

The block runs entirely on the fast clock. It produces its own sample-take strobe, and the upstream logic must hold the sample and flag valid in the cycle where that strobe is high. The format input selects the frame format. It must be held constant while the block is out of reset, and the block must be reset whenever the format changes.

Top module: `ser2_serializer`

## Requirements
- R1: In the data slots `s = 0..5` of a sample, `lane_a` carries data bit `11-2s` and `lane_b` carries data bit `10-2s`. The first slot therefore carries D11 on `lane_a` and D10 on `lane_b`.
- R2: With `fmt_narrow` = 0, each sample takes eight slots. Slot 7 is 0 on both lanes.
- R3: With `fmt_narrow` = 1, each sample takes seven slots. There is no zero slot: the flag slot (slot 6) is followed directly by slot 0 of the next sample.
- R4: In slot 6, both lanes carry the overrange flag of the sample being sent: 1 when the flag was set and 0 otherwise.
- R5: `smp_take` is high in the last slot cycle of every sample and low in every other cycle. `smp_data` and `smp_ovr` are captured on the clock edge that ends a cycle in which `smp_take` is high.
- R6: A sample captured at boundary k is sent in the slots that follow boundary k+6, a latency of six samples.
- R7: After reset, the lanes carry only zeros until the first boundary and during the six samples that follow it.
- R8: With `fmt_narrow` = 0, once the first boundary has passed, `frame` is 1 in slots 0 to 3 and 0 in slots 4 to 7.
- R9: With `fmt_narrow` = 1, `frame` holds one level for the whole of a sample and inverts at every boundary. It is 1 during the first sample after reset, so it has a period of two samples.
- R10: `frame` stays 0 from reset until the first boundary.
- R11: While `rst_n` is low, `lane_a`, `lane_b`, `frame` and `smp_take` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast bit-slot clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fmt_narrow | input | 1 | 0: eight-slot format, 1: seven-slot format |
| smp_data | input | 12 | Sample value; bit 11 is D11 |
| smp_ovr | input | 1 | Overrange flag of the sample |
| smp_take | output | 1 | High in the cycle whose closing edge captures the sample |
| lane_a | output | 1 | Odd-bit lane |
| lane_b | output | 1 | Even-bit lane |
| frame | output | 1 | Sample-boundary marker |

## Verification
The bench drives the data inputs with a new value every cycle, including the cycles in which the sample is not being taken. A design that captures the sample one cycle early or late therefore sends the wrong word and fails the bit-by-bit comparison.

A behavioural receiver rebuilds each word from the two lanes and matches it against the sample captured six boundaries earlier. This catches a pipeline that is one stage too short or too long, and it also catches a swapped lane order.

Overrange patterns that are constant and patterns that alternate exercise the flag slot. These show a flag filler stuck at 0 and a flag taken from the wrong sample.

Both frame formats are run from reset. This exposes a zero slot left in the seven-slot format, a frame that toggles in the middle of a sample, and a frame that rises before the first boundary.

// File: rtl/ser2_pkg.sv
package ser2_pkg;

  typedef enum logic {
    FMT_WIDE   = 1'b0,
    FMT_NARROW = 1'b1
  } fmt_e;

  // Slots per lane for one sample: data pairs plus the flag slot, plus a zero slot in the wide format.
  function automatic int unsigned slot_count(int unsigned dw, fmt_e fmt);
    return (fmt == FMT_NARROW) ? dw / 2 + 1 : dw / 2 + 2;
  endfunction

  // Index of the slot that carries the overrange flag.
  function automatic int unsigned flag_slot(int unsigned dw);
    return dw / 2;
  endfunction

  // First slot in which the wide-format frame is low.
  function automatic int unsigned wide_half(int unsigned dw);
    return (dw / 2 + 2) / 2;
  endfunction

endpackage

// File: rtl/ser2_slot_timer.sv
module ser2_slot_timer
  import ser2_pkg::*;
#(
  parameter int DW = 12,
  parameter int SW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  fmt_e          fmt,
  output logic [SW-1:0] slot,
  output logic          take,
  output logic          started,
  output logic          frame_tgl
);

  logic [SW-1:0] last_slot;

  assign last_slot = SW'(slot_count(DW, fmt) - 1);
  assign take      = (slot == last_slot);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot      <= '0;
      started   <= 1'b0;
      frame_tgl <= 1'b0;
    end else if (take) begin
      slot      <= '0;
      started   <= 1'b1;
      frame_tgl <= ~frame_tgl;
    end else begin
      slot <= slot + 1'b1;
    end
  end

endmodule

// File: rtl/ser2_delay_line.sv
module ser2_delay_line #(
  parameter int W   = 13,
  parameter int LAT = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] stg [LAT];

  for (genvar gi = 0; gi < LAT; gi++) begin : g_stage
    logic [W-1:0] src;
    if (gi == 0) begin : g_head
      assign src = din;
    end else begin : g_body
      assign src = stg[gi-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   stg[gi] <= '0;
      else if (adv) stg[gi] <= src;
    end
  end

  assign dout = stg[LAT-1];

endmodule

// File: rtl/ser2_lane_sel.sv
module ser2_lane_sel #(
  parameter int DW = 12,
  parameter int SW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW:0]   word_in,
  input  logic [SW-1:0] slot,
  output logic          lane_a,
  output logic          lane_b
);

  logic [DW:0] word_q;

  // Bit carried on one lane in a given slot. The flag sits at position DW of the word.
  function automatic logic pick(logic [DW:0] w, int unsigned s, logic even_lane);
    int unsigned idx;
    if (s < DW / 2) begin
      idx = DW - 1 - 2 * s - (even_lane ? 1 : 0);
      return w[idx];
    end else if (s == DW / 2) begin
      return w[DW];
    end
    return 1'b0;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    word_q <= '0;
    else if (load) word_q <= word_in;
  end

  assign lane_a = pick(word_q, int'(slot), 1'b0);
  assign lane_b = pick(word_q, int'(slot), 1'b1);

endmodule

// File: rtl/ser2_serializer.sv
module ser2_serializer
  import ser2_pkg::*;
#(
  parameter int DW  = 12,
  parameter int LAT = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fmt_narrow,
  input  logic [DW-1:0] smp_data,
  input  logic          smp_ovr,
  output logic          smp_take,
  output logic          lane_a,
  output logic          lane_b,
  output logic          frame
);

  localparam int SW = $clog2(DW / 2 + 2);

  fmt_e          fmt;
  logic [SW-1:0] slot;
  logic          take;
  logic          started;
  logic          frame_tgl;
  logic [DW:0]   pipe_out;
  logic [SW-1:0] half_slot;

  assign fmt       = fmt_e'(fmt_narrow);
  assign half_slot = SW'(wide_half(DW));

  ser2_slot_timer #(.DW(DW), .SW(SW)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .fmt       (fmt),
    .slot      (slot),
    .take      (take),
    .started   (started),
    .frame_tgl (frame_tgl)
  );

  ser2_delay_line #(.W(DW + 1), .LAT(LAT)) u_delay (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (take),
    .din   ({smp_ovr, smp_data}),
    .dout  (pipe_out)
  );

  ser2_lane_sel #(.DW(DW), .SW(SW)) u_lanes (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (take),
    .word_in (pipe_out),
    .slot    (slot),
    .lane_a  (lane_a),
    .lane_b  (lane_b)
  );

  assign smp_take = take;
  assign frame    = started && ((fmt == FMT_NARROW) ? frame_tgl : (slot < half_slot));

endmodule

// File: rtl/ser2_checks.sv
module ser2_checks #(
  parameter int DW = 12,
  parameter int SW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fmt_narrow,
  input logic          take,
  input logic [SW-1:0] slot,
  input logic          started,
  input logic          lane_a,
  input logic          lane_b,
  input logic          frame
);

  localparam logic [SW-1:0] FLAG = SW'(DW / 2);
  localparam logic [SW-1:0] TAIL = SW'(DW / 2 + 1);
  localparam logic [SW-1:0] HALF = SW'((DW / 2 + 2) / 2);

  AST_TAKE_SPACED: assert property (@(posedge clk) disable iff (!rst_n) take |=> !take); // R5
  AST_FRAME_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !started |-> !frame); // R10
  AST_WIDE_FRAME_RISE: assert property (@(posedge clk) disable iff (!rst_n) (take && !fmt_narrow) |=> frame); // R8
  AST_WIDE_FRAME_FALL: assert property (@(posedge clk) disable iff (!rst_n) (started && !fmt_narrow && slot == HALF) |-> !frame); // R8
  AST_NARROW_FRAME_FLIP: assert property (@(posedge clk) disable iff (!rst_n) (take && fmt_narrow) |=> (frame != $past(frame))); // R9
  AST_NARROW_FRAME_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (fmt_narrow && !take) |=> $stable(frame)); // R9
  AST_WIDE_TAIL_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (!fmt_narrow && slot == TAIL) |-> (!lane_a && !lane_b)); // R2
  AST_FLAG_PAIR: assert property (@(posedge clk) disable iff (!rst_n) (slot == FLAG) |-> (lane_a == lane_b)); // R4
  AST_NARROW_NO_TAIL: assert property (@(posedge clk) disable iff (!rst_n) fmt_narrow |-> (slot <= FLAG)); // R3

endmodule

bind ser2_serializer ser2_checks #(.DW(DW), .SW(SW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .fmt_narrow (fmt_narrow),
  .take       (take),
  .slot       (slot),
  .started    (started),
  .lane_a     (lane_a),
  .lane_b     (lane_b),
  .frame      (frame)
);

// File: tb/ser2_serializer_test.sv
`timescale 1ns/1ps
module ser2_serializer_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fmt_narrow = 1'b0;
  logic [11:0] smp_data = '0;
  logic        smp_ovr = 1'b0;
  logic        smp_take, lane_a, lane_b, frame;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  ser2_serializer uut (
    .clk(clk), .rst_n(rst_n), .fmt_narrow(fmt_narrow),
    .smp_data(smp_data), .smp_ovr(smp_ovr),
    .smp_take(smp_take), .lane_a(lane_a), .lane_b(lane_b), .frame(frame)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Reference state: word = {ovr, data}
  logic [12:0] pipe_q [$];
  logic [12:0] sent [$];
  logic [12:0] cur;
  logic [12:0] rx;
  int          mslot, bnum;
  bit          mstart, mtgl;

  function automatic bit exp_bit(logic [12:0] w, int s, bit even);
    if (s < 6) return w[11 - 2*s - (even ? 1 : 0)];
    if (s == 6) return w[12];
    return 1'b0;
  endfunction

  task automatic run_phase(bit nar, int cycles, int pat);
    int last;
    last = nar ? 6 : 7;
    @(negedge clk);
    rst_n = 1'b0;
    fmt_narrow = nar;
    repeat (3) begin
      @(negedge clk);
      chk("R11 lane_a in reset", lane_a, 0);
      chk("R11 lane_b in reset", lane_b, 0);
      chk("R11 frame in reset", frame, 0);
      chk("R11 take in reset", smp_take, 0);
    end
    pipe_q.delete();
    sent.delete();
    for (int i = 0; i < 6; i++) pipe_q.push_back('0);
    cur = '0; rx = '0; mslot = 0; bnum = 0; mstart = 0; mtgl = 0;
    rst_n = 1'b1;
    for (int c = 0; c < cycles; c++) begin
      string rq;
      bit    ef;
      // compare current cycle
      rq = (mslot < 6) ? "R1 slot bit" : (mslot == 6) ? "R4 flag slot" : "R2 zero slot";
      if (bnum <= 6) rq = {rq, " (R7 fill)"};
      chk(rq, lane_a, exp_bit(cur, mslot, 0));
      chk(rq, lane_b, exp_bit(cur, mslot, 1));
      if (!mstart)  ef = 0;
      else if (nar) ef = mtgl;
      else          ef = (mslot < 4);
      chk(!mstart ? "R10 frame idle" : nar ? "R9 narrow frame" : "R8 wide frame", frame, ef);
      chk(nar ? "R3/R5 take in seven-slot frame" : "R2/R5 take in eight-slot frame",
          smp_take, (mslot == last));
      // behavioural receiver
      if (mslot < 6) begin
        rx[11 - 2*mslot] = lane_a;
        rx[10 - 2*mslot] = lane_b;
      end else if (mslot == 6) begin
        rx[12] = lane_a;
      end
      if (mslot == last) begin
        if (bnum >= 7) chk("R6 recovered word latency", rx, sent[bnum-7]);
        else           chk("R7 recovered word before fill", rx, 0);
      end
      // drive new inputs
      case (pat)
        0: begin smp_data = 12'($urandom); smp_ovr = ($urandom % 4) == 0; end
        1: begin smp_data = 12'hFFF; smp_ovr = 1'b0; end
        2: begin smp_data = bnum[0] ? 12'hAAA : 12'h555; smp_ovr = bnum[0]; end
        default: begin smp_data = 12'h000; smp_ovr = 1'b1; end
      endcase
      if (pat == 1 || pat == 3) smp_data = smp_data ^ (c[0] ? 12'h0 : 12'h0);
      if (pat != 0 && mslot != last) smp_data = 12'($urandom);
      // advance model across the coming edge
      if (mslot == last) begin
        pipe_q.push_back({smp_ovr, smp_data});
        sent.push_back({smp_ovr, smp_data});
        cur = pipe_q.pop_front();
        bnum++;
        mstart = 1; mtgl = ~mtgl; mslot = 0; rx = '0;
      end else begin
        mslot++;
      end
      @(negedge clk);
    end
  endtask

  initial begin
    #(100000 * 5);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int p = 0; p < 4; p++) begin
      run_phase(1'b0, 400, p);
      run_phase(1'b1, 400, p);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule